// File: doc/BRIEF.md
# Receive FIFO Forwarding Gate

This block sits between the byte stream a receive MAC writes into its FIFO and the receive DMA that empties it. For every frame it decides whether the bytes are passed on or dropped. Only bytes behind a commit pointer are visible on the read side. In store-and-forward mode that pointer moves when a whole frame has arrived and is found good. In cut-through mode it starts to follow the write pointer as soon as the frame is long enough, measured against a programmable byte threshold, and the address filter has accepted the frame.

A frame is dropped if the address filter rejects it, if no filter verdict arrives, if it ends shorter than the minimum length, or if it ends with a collision or abort flag. It is also dropped if it runs out of buffer space before anything of it has been released. Dropping moves the write pointer back to where the frame began, so none of its bytes ever appear at the read side. A frame that is already being forwarded cannot be pulled back. It runs to its end, and its final entry carries an error flag. A saturating counter records the number of dropped frames. The storage is a plain circular buffer of entries, each holding a data byte, an end marker and an error flag.

Top module: `rxg_gate`

## Requirements
- R1: After reset the read side shows no valid entry, `drop_cnt` is zero, and neither `fwd_go` nor `frm_drop` is high.
- R2: With `mode_sf`=1 no byte of a frame is readable before its end beat is accepted. A good frame then becomes readable in full and in order, with `rd_last`=1 only on its final byte. `fwd_go` pulses once, in the cycle after the end beat.
- R3: With `mode_sf`=0, forwarding starts on the first beat after which three conditions hold: the beat count is at least max(`thresh`, MIN_LEN), a pass verdict has been taken, and there is no overrun. From the next cycle the stored bytes are readable and `fwd_go` pulses once. A frame that does not start early is treated as in R2.
- R4: The filter verdict (`filt_valid` with `filt_pass`) is taken once per frame, on the first report while the frame is open. A frame with a fail verdict, or with no verdict, is dropped: nothing of it is readable, and `frm_drop` pulses once in the cycle after its end beat.
- R5: A frame whose beat count at its end is below MIN_LEN (64) is dropped.
- R6: A frame not yet forwarding is dropped if its end beat carries `in_col` or `in_abort`.
- R7: A frame already forwarding when it ends with `in_col`, `in_abort` or an overrun is delivered completely. Its final entry has `rd_last`=1 and `rd_err`=1, and no drop is counted. `rd_err` is never 1 on any other entry.
- R8: Dropping leaves no residue. The next good frame is read back exactly, with no bytes left over from the dropped frame. A readable entry stays valid and unchanged until it is popped with `rd_ready`.
- R9: `drop_cnt` rises by one in the cycle after each `frm_drop` pulse and holds at 2^CNT_W-1.
- R10: A non-end beat is stored only while at least two entries are free, and an end beat needs one free entry. Once a beat is refused, the frame is in overrun and stores no more non-end beats. An overrun frame that is not yet forwarding is dropped at its end.
- R11: Beats that arrive while no frame is open and that lack `in_sof` are ignored. Nothing becomes readable and no pulse is produced.
- R12: A pass verdict that arrives after the threshold count was already reached starts cut-through forwarding on that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A byte beat is present |
| in_data | input | 8 | Beat data byte |
| in_sof | input | 1 | Beat is the first of a frame |
| in_eof | input | 1 | Beat is the last of a frame |
| in_col | input | 1 | Collision seen; valid with the end beat |
| in_abort | input | 1 | Early termination; valid with the end beat |
| filt_valid | input | 1 | Address filter verdict present |
| filt_pass | input | 1 | Verdict: 1 accept, 0 reject |
| mode_sf | input | 1 | 1 store-and-forward, 0 cut-through |
| thresh | input | THR_W | Cut-through start threshold in bytes |
| rd_ready | input | 1 | Read side takes the shown entry |
| rd_valid | output | 1 | A committed entry is shown |
| rd_data | output | 8 | Entry data byte |
| rd_last | output | 1 | Entry is a frame's final byte |
| rd_err | output | 1 | Forwarded frame ended badly |
| fwd_go | output | 1 | One-cycle pulse: a frame was released |
| frm_drop | output | 1 | One-cycle pulse: a frame was discarded |
| drop_cnt | output | CNT_W | Saturating count of discarded frames |

## Verification
If the frame-start pointer is stale, the next released frame begins with stray bytes on `rd_data`, and `rd_valid` rises early. A commit pointer that runs ahead or lags shows up on `rd_valid` one cycle after the offending beat. The bench checks that cycle against the threshold arithmetic for every length, threshold, verdict and termination in its sweep. A wrong overrun or verdict flag turns into the wrong pulse on `fwd_go` or `frm_drop` one cycle after the end beat. A wrong count shows on `drop_cnt` one cycle later.

// File: rtl/rxg_pkg.sv
package rxg_pkg;

    localparam int RXG_BYTE_W = 8;

    // one buffer slot: data byte plus frame markers
    typedef struct packed {
        logic                  err;
        logic                  last;
        logic [RXG_BYTE_W-1:0] data;
    } rxg_ent_t;

endpackage

// File: rtl/rxg_buf.sv
module rxg_buf
    import rxg_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  rxg_ent_t      wr_ent,
    input  logic [AW:0]   cmt_ptr,
    input  logic          rd_ready,
    output logic [AW:0]   rd_ptr,
    output logic          rd_valid,
    output rxg_ent_t      rd_ent
);

    rxg_ent_t    mem [DEPTH];
    logic [AW:0] rd_d, rd_q;
    logic        pop;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_ent;
        end
    end

    always_comb begin
        rd_valid = (rd_q != cmt_ptr);
        pop      = rd_valid && rd_ready;
        rd_d     = rd_q;
        if (pop) begin
            rd_d = rd_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_ptr = rd_q;
    assign rd_ent = mem[rd_q[AW-1:0]];

endmodule

// File: rtl/rxg_ctrl.sv
module rxg_ctrl
    import rxg_pkg::*;
#(
    parameter int DEPTH   = 256,
    parameter int AW      = $clog2(DEPTH),
    parameter int THR_W   = 11,
    parameter int MIN_LEN = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [RXG_BYTE_W-1:0] in_data,
    input  logic                  in_sof,
    input  logic                  in_eof,
    input  logic                  in_col,
    input  logic                  in_abort,
    input  logic                  filt_valid,
    input  logic                  filt_pass,
    input  logic                  mode_sf,
    input  logic [THR_W-1:0]      thresh,
    input  logic [AW:0]           rd_ptr,
    output logic                  wr_en,
    output logic [AW-1:0]         wr_addr,
    output rxg_ent_t              wr_ent,
    output logic [AW:0]           cmt_ptr,
    output logic                  fwd_go,
    output logic                  frm_drop
);

    // length counter is one bit wider than the threshold so it can pass it
    localparam int LEN_W = THR_W + 1;
    localparam logic [LEN_W-1:0] MINL = LEN_W'(MIN_LEN);
    localparam logic [AW+1:0]    CAP  = (AW+2)'(DEPTH);

    typedef struct packed {
        logic             open;
        logic             fwd;
        logic             fknown;
        logic             fok;
        logic             ovr;
        logic [LEN_W-1:0] len;
        logic [AW:0]      wr;
        logic [AW:0]      sofp;
        logic [AW:0]      cmt;
        logic             go;
        logic             drop;
    } st_t;

    st_t              st_d, st_q;
    logic [AW:0]      used;
    logic [AW+1:0]    free;
    logic [LEN_W-1:0] thr_ext, eff_thr;
    logic             start, store, bad, good;

    always_comb begin
        thr_ext = LEN_W'(thresh);
        eff_thr = (thr_ext < MINL) ? MINL : thr_ext;
    end

    always_comb begin
        st_d      = st_q;
        st_d.go   = 1'b0;
        st_d.drop = 1'b0;
        wr_en     = 1'b0;
        wr_ent    = '0;
        store     = 1'b0;
        bad       = 1'b0;
        good      = 1'b0;
        used      = st_q.wr - rd_ptr;
        free      = CAP - {1'b0, used};
        start     = in_valid && in_sof && !st_q.open;

        if (start) begin
            st_d.open   = 1'b1;
            st_d.fwd    = 1'b0;
            st_d.fknown = 1'b0;
            st_d.fok    = 1'b0;
            st_d.ovr    = 1'b0;
            st_d.len    = '0;
            st_d.sofp   = st_q.wr;
        end

        // take the first filter verdict of the open frame
        if (filt_valid && st_d.open && !st_d.fknown) begin
            st_d.fknown = 1'b1;
            st_d.fok    = filt_pass;
        end

        if (in_valid && st_d.open) begin
            if (in_eof) begin
                store = (free >= (AW+2)'(1));
            end else begin
                store = (free >= (AW+2)'(2)) && !st_d.ovr;
            end
            if (!store) begin
                st_d.ovr = 1'b1;
            end
            if (st_d.len != '1) begin
                st_d.len = st_d.len + 1'b1;
            end
            bad = in_col || in_abort || st_d.ovr;
            if (store) begin
                wr_en       = 1'b1;
                wr_ent.data = in_data;
                wr_ent.last = in_eof;
                wr_ent.err  = in_eof && bad;
                st_d.wr     = st_q.wr + 1'b1;
            end
            if (in_eof) begin
                st_d.open = 1'b0;
                good = !bad && (st_d.len >= MINL) && st_d.fknown && st_d.fok;
                if (st_d.fwd) begin
                    st_d.cmt = st_d.wr;
                end else if (good) begin
                    st_d.cmt = st_d.wr;
                    st_d.go  = 1'b1;
                end else begin
                    st_d.wr   = st_d.sofp;
                    st_d.drop = 1'b1;
                end
            end
        end

        // cut-through release once long enough and accepted
        if (st_d.open && !st_d.fwd && !mode_sf && !st_d.ovr &&
            st_d.fknown && st_d.fok && (st_d.len >= eff_thr)) begin
            st_d.fwd = 1'b1;
            st_d.go  = 1'b1;
        end
        if (st_d.open && st_d.fwd) begin
            st_d.cmt = st_d.wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_addr  = st_q.wr[AW-1:0];
    assign cmt_ptr  = st_q.cmt;
    assign fwd_go   = st_q.go;
    assign frm_drop = st_q.drop;

endmodule

// File: rtl/rxg_satcnt.sv
module rxg_satcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != '1)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/rxg_gate.sv
module rxg_gate
    import rxg_pkg::*;
#(
    parameter int DEPTH   = 256,
    parameter int THR_W   = 11,
    parameter int MIN_LEN = 64,
    parameter int CNT_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [RXG_BYTE_W-1:0] in_data,
    input  logic                  in_sof,
    input  logic                  in_eof,
    input  logic                  in_col,
    input  logic                  in_abort,
    input  logic                  filt_valid,
    input  logic                  filt_pass,
    input  logic                  mode_sf,
    input  logic [THR_W-1:0]      thresh,
    input  logic                  rd_ready,
    output logic                  rd_valid,
    output logic [RXG_BYTE_W-1:0] rd_data,
    output logic                  rd_last,
    output logic                  rd_err,
    output logic                  fwd_go,
    output logic                  frm_drop,
    output logic [CNT_W-1:0]      drop_cnt
);

    // DEPTH must be a power of two for pointer wrap
    localparam int AW = $clog2(DEPTH);

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    rxg_ent_t      wr_ent;
    rxg_ent_t      rd_ent;
    logic [AW:0]   cmt_ptr;
    logic [AW:0]   rd_ptr;

    rxg_ctrl #(
        .DEPTH  (DEPTH),
        .AW     (AW),
        .THR_W  (THR_W),
        .MIN_LEN(MIN_LEN)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .in_col    (in_col),
        .in_abort  (in_abort),
        .filt_valid(filt_valid),
        .filt_pass (filt_pass),
        .mode_sf   (mode_sf),
        .thresh    (thresh),
        .rd_ptr    (rd_ptr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_ent    (wr_ent),
        .cmt_ptr   (cmt_ptr),
        .fwd_go    (fwd_go),
        .frm_drop  (frm_drop)
    );

    rxg_buf #(
        .DEPTH(DEPTH),
        .AW   (AW)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_ent  (wr_ent),
        .cmt_ptr (cmt_ptr),
        .rd_ready(rd_ready),
        .rd_ptr  (rd_ptr),
        .rd_valid(rd_valid),
        .rd_ent  (rd_ent)
    );

    rxg_satcnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (frm_drop),
        .cnt  (drop_cnt)
    );

    assign rd_data = rd_ent.data;
    assign rd_last = rd_ent.last;
    assign rd_err  = rd_ent.err;

endmodule

// File: rtl/rxg_gate_chk.sv
module rxg_gate_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_eof,
    input logic             mode_sf,
    input logic             rd_ready,
    input logic             rd_valid,
    input logic [7:0]       rd_data,
    input logic             rd_last,
    input logic             rd_err,
    input logic             fwd_go,
    input logic             frm_drop,
    input logic [CNT_W-1:0] drop_cnt
);

    p_sf_release_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sf && !(in_valid && in_eof)) |=> !fwd_go);

    p_go_drop_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_go && frm_drop));

    p_err_on_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_err) |-> rd_last);

    p_entry_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last) && $stable(rd_err)));

    p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_drop && (drop_cnt != {CNT_W{1'b1}})) |=> (drop_cnt == $past(drop_cnt) + CNT_W'(1)));

    p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_drop |=> $stable(drop_cnt));

endmodule

bind rxg_gate rxg_gate_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_eof  (in_eof),
    .mode_sf (mode_sf),
    .rd_ready(rd_ready),
    .rd_valid(rd_valid),
    .rd_data (rd_data),
    .rd_last (rd_last),
    .rd_err  (rd_err),
    .fwd_go  (fwd_go),
    .frm_drop(frm_drop),
    .drop_cnt(drop_cnt)
);

// File: tb/rxg_gate_tb.sv
module rxg_gate_tb;

    localparam int CLK_P   = 10;
    localparam int DEPTH   = 128;
    localparam int THR_W   = 8;
    localparam int CNT_W   = 4;
    localparam int MIN_LEN = 64;
    localparam int FA      = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic             in_col = 1'b0, in_abort = 1'b0;
    logic [7:0]       in_data = '0;
    logic             filt_valid = 1'b0, filt_pass = 1'b0;
    logic             mode_sf = 1'b0;
    logic [THR_W-1:0] thresh = '0;
    logic             rd_ready = 1'b0;
    logic             rd_valid, rd_last, rd_err, fwd_go, frm_drop;
    logic [7:0]       rd_data;
    logic [CNT_W-1:0] drop_cnt;

    int total = 0, bad = 0, exp_drops = 0, go_seen = 0, drop_seen = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rxg_gate #(.DEPTH(DEPTH), .THR_W(THR_W), .MIN_LEN(MIN_LEN), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .in_col(in_col), .in_abort(in_abort),
        .filt_valid(filt_valid), .filt_pass(filt_pass), .mode_sf(mode_sf),
        .thresh(thresh), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_last(rd_last), .rd_err(rd_err), .fwd_go(fwd_go), .frm_drop(frm_drop),
        .drop_cnt(drop_cnt)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            go_seen   += int'(fwd_go);
            drop_seen += int'(frm_drop);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_col = 1'b0;
        in_abort = 1'b0; filt_valid = 1'b0; filt_pass = 1'b0;
    endtask

    // filt: 0 none, 1 pass, 2 fail; term: 0 clean, 1 collision, 2 abort
    task automatic send_frame(input int len, input bit sf, input int thr, input int filt,
                              input int fat, input int term, input int seed);
        int  eff     = (thr > MIN_LEN) ? thr : MIN_LEN;
        bit  started = 1'b0;
        bit  ovr     = 1'b0;
        int  stored  = 0;
        int  mism    = 0;
        bit  fwd, good, exp_err;
        int  exp_cnt, got, dmis, lmis, emis;
        mode_sf = sf;
        thresh  = THR_W'(thr);
        go_seen = 0;
        drop_seen = 0;
        rd_ready = 1'b0;
        for (int i = 0; i < len; i++) begin
            in_valid   = 1'b1;
            in_data    = 8'(seed + i);
            in_sof     = (i == 0);
            in_eof     = (i == len - 1);
            in_col     = (i == len - 1) && (term == 1);
            in_abort   = (i == len - 1) && (term == 2);
            filt_valid = (filt != 0) && (i == fat);
            filt_pass  = (filt == 1);
            @(negedge clk);
            if (i != len - 1) begin
                if (!ovr && (DEPTH - stored) >= 2) stored++;
                else ovr = 1'b1;
                if (!started && !sf && filt == 1 && (i + 1) > fat && (i + 1) >= eff && !ovr)
                    started = 1'b1;
                if (rd_valid != started) mism++;
            end
        end
        idle_inputs();
        good    = (term == 0) && !ovr && (len >= MIN_LEN) && (filt == 1) && (fat < len);
        fwd     = started || good;
        exp_err = started && (term != 0 || ovr);
        exp_cnt = fwd ? (stored + 1) : 0;
        // R3: cut-through release cycle, R2: nothing early in store-and-forward
        chk(sf ? "R2 no early release" : "R3 release cycle", mism, 0);
        repeat (2) @(negedge clk);
        chk("R2/R3 fwd_go pulses", go_seen, int'(fwd));
        chk("R4/R5/R6 frm_drop pulses", drop_seen, int'(!fwd));
        if (!fwd && exp_drops < (1 << CNT_W) - 1) exp_drops++;
        chk("R9 drop_cnt", int'(drop_cnt), exp_drops);
        // drain and compare contents
        rd_ready = 1'b1;
        got = 0; dmis = 0; lmis = 0; emis = 0;
        while (rd_valid && got < 300) begin
            int idx = (ovr && got == stored) ? (len - 1) : got;
            if (rd_data != 8'(seed + idx)) dmis++;
            if (rd_last != (got == exp_cnt - 1)) lmis++;
            if (rd_err != ((got == exp_cnt - 1) && exp_err)) emis++;
            got++;
            @(negedge clk);
        end
        rd_ready = 1'b0;
        chk("R8 entries readable", got, exp_cnt);
        chk("R8 data order", dmis, 0);
        chk("R2 last marker", lmis, 0);
        chk("R7 error marker", emis, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=1 exp=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lens[5] = '{1, 63, 64, 65, 90};
        int thrs[4] = '{0, 64, 70, 200};
        int seed = 3;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 drop_cnt", int'(drop_cnt), 0);
        chk("R1 pulses", int'(fwd_go) + int'(frm_drop), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: stray beats with no open frame
        go_seen = 0; drop_seen = 0;
        for (int i = 0; i < 5; i++) begin
            in_valid = 1'b1; in_data = 8'(i); in_eof = (i == 4);
            @(negedge clk);
        end
        idle_inputs();
        repeat (2) @(negedge clk);
        chk("R11 stray beats unread", int'(rd_valid), 0);
        chk("R11 stray beats no pulse", go_seen + drop_seen, 0);
        // sweep: length x mode x threshold x verdict x termination
        for (int l = 0; l < 5; l++)
            for (int m = 0; m < 2; m++)
                for (int t = 0; t < 4; t++)
                    for (int f = 0; f < 3; f++)
                        for (int e = 0; e < 3; e++) begin
                            send_frame(lens[l], bit'(m), thrs[t], f, FA, e, seed);
                            seed += 7;
                        end
        // R12: late pass verdict after threshold reached
        send_frame(90, 1'b0, 64, 1, 80, 0, 11);
        send_frame(90, 1'b0, 64, 1, 80, 1, 12);
        // R10: overrun in store-and-forward is dropped
        send_frame(140, 1'b1, 64, 1, FA, 0, 21);
        // R10/R7: overrun after cut-through start is truncated and flagged
        send_frame(140, 1'b0, 64, 1, FA, 0, 22);
        // R8: good frame right after a drop comes out clean
        send_frame(30, 1'b1, 0, 1, FA, 0, 40);
        send_frame(70, 1'b1, 0, 1, FA, 0, 41);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule